// File: doc/BRIEF.md
# Segmented Carry-Speculating Adder

A combinational approximate adder for two unsigned operands (16 bits by default). The operand width is cut into equal segments, four of 4 bits by default. Each segment has a group carry generator, which looks only at that segment's own operand bits, and a sum generator. The sum generator of a segment takes a speculated carry-in that is built from a short window of lower segments, always evaluated with a zero carry entering the window. A carry therefore never travels through more than a bounded number of segments. This keeps the longest carry path short: it spans two segments in the basic scheme, against the full width in a ripple adder.

A build-time mode selects between two schemes. The basic scheme speculates each segment's carry from the one segment directly below it. The cascaded scheme chains lower group carry generators. Each upper segment then sees up to two lower segments, and the top segment sees up to three. This makes the high-order bits, which carry the most weight, more accurate at the cost of a longer carry path. The block fits error-tolerant datapaths such as pixel arithmetic, where a rare wrong low-weight result costs less than the delay of a full carry chain.

Top module: `specAdder`

## Requirements
- R1: Segment k of `sum` (bits k*SEG_W up to k*SEG_W+SEG_W-1) equals the low SEG_W bits of that segment's slice of `opA` plus its slice of `opB` plus the segment's speculated carry-in.
- R2: The lowest segment uses a carry-in of 0, so the lowest SEG_W bits of `sum` always equal the low SEG_W bits of the exact sum.
- R3: In basic mode (MODE = MODE_BASIC, encoding 0), the carry-in of segment k (k at least 1) is the carry out of segment k-1 alone, with 0 entering segment k-1.
- R4: In cascaded mode (MODE = MODE_CASCADE, encoding 1), the carry-in of a segment below the top is the carry out of the window of up to two segments directly below it. The top segment's carry-in comes from a window of up to three segments. Each window is evaluated with 0 entering its lowest bit.
- R5: `carryOut` is the carry leaving the top segment when that segment adds its operand slices and its speculated carry-in.
- R6: In basic mode, when no segment from 1 to SEGS-2 has every bit position with exactly one operand bit set, {`carryOut`,`sum`} equals the exact sum.
- R7: When no bit position has both operand bits set, `sum` equals `opA` XOR `opB` and `carryOut` is 0.
- R8: In cascaded mode with at most four segments, {`carryOut`,`sum`} equals the exact sum for every operand pair.
- R9: In basic mode, a carry that would have to cross two segment boundaries is dropped: 0x00FF + 0x0001 yields `sum` 0x0000 with `carryOut` 0, and 0xFFFF + 0x0001 yields `sum` 0xFF00 with `carryOut` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand, unsigned |
| opB | input | WIDTH | Second operand, unsigned |
| sum | output | WIDTH | Approximate sum, one segment per SEG_W bits |
| carryOut | output | 1 | Carry leaving the top segment |

## Verification
The block holds no state. A wrong internal value is a mis-speculated segment carry-in, and it shows in the same evaluation as a sum segment that is off by exactly one unit of that segment's weight. In the top segment it can also show as a flipped `carryOut`. Such a fault only appears for operands where the faulty window's carry matters. For that reason the stimulus forces segments into the all-propagate pattern, where each window's zero-carry assumption decides the result, and the bench compares both modes against a window-based model on every vector.

// File: rtl/spec_adder_pkg.sv
package spec_adder_pkg;

  typedef enum logic {
    MODE_BASIC   = 1'b0,
    MODE_CASCADE = 1'b1
  } spec_mode_e;

  // Number of lower segments whose group carries feed segment seg.
  function automatic int windowSegs(input spec_mode_e mode, input int seg,
                                    input int segCount);
    int w;
    if (mode == MODE_BASIC)       w = 1;
    else if (seg == segCount - 1) w = 3;
    else                          w = 2;
    if (w > seg) w = seg;
    return w;
  endfunction

endpackage

// File: rtl/specCarryGen.sv
module specCarryGen #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] segA,
  input  logic [SEG_W-1:0] segB,
  output logic             grpGen,
  output logic             grpProp
);

  always_comb begin
    logic g;
    logic p;
    g = 1'b0;
    p = 1'b1;
    for (int i = 0; i < SEG_W; i++) begin
      g = (segA[i] & segB[i]) | ((segA[i] ^ segB[i]) & g);
      p = p & (segA[i] ^ segB[i]);
    end
    grpGen  = g;
    grpProp = p;
  end

  // Group generate and group propagate cannot both be set.
  always_comb begin
    assert_gen_prop_excl_R1: assert (!(grpGen && grpProp));
  end

endmodule

// File: rtl/specCarryNet.sv
module specCarryNet
  import spec_adder_pkg::*;
#(
  parameter int         SEGS = 4,
  parameter spec_mode_e MODE = MODE_BASIC
) (
  input  logic [SEGS-2:0] lowGen,
  input  logic [SEGS-2:0] lowProp,
  output logic [SEGS-1:0] carryIn
);

  assign carryIn[0] = 1'b0;

  for (genvar k = 1; k < SEGS; k++) begin : gSeg
    localparam int W = windowSegs(MODE, k, SEGS);
    logic segC;

    always_comb begin
      logic c;
      c = 1'b0;
      for (int j = k - W; j < k; j++) c = lowGen[j] | (lowProp[j] & c);
      segC = c;
    end

    assign carryIn[k] = segC;

    // A speculated carry needs a generating segment inside its window.
    always_comb begin
      if (segC) assert_carry_has_source_R4: assert (|lowGen[k-1 -: W]);
    end

    // The segment right below always decides the carry when it does not propagate.
    always_comb begin
      if (!lowProp[k-1])
        assert_near_segment_decides_R3: assert (segC == lowGen[k-1]);
    end
  end

endmodule

// File: rtl/specSumGen.sv
module specSumGen #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] segA,
  input  logic [SEG_W-1:0] segB,
  input  logic             carryIn,
  output logic [SEG_W-1:0] segSum
);

  assign segSum = segA + segB + {{(SEG_W-1){1'b0}}, carryIn};

endmodule

// File: rtl/specAdder.sv
module specAdder
  import spec_adder_pkg::*;
#(
  parameter int         WIDTH = 16,
  parameter int         SEGS  = 4,
  parameter spec_mode_e MODE  = MODE_BASIC
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  localparam int SEG_W = WIDTH / SEGS;
  localparam int TOP   = SEGS - 1;

  logic [SEGS-1:0] segGen;
  logic [SEGS-1:0] segProp;
  logic [SEGS-1:0] carryIn;

  for (genvar k = 0; k < SEGS; k++) begin : gSeg
    specCarryGen #(.SEG_W(SEG_W)) carryGen_i (
      .segA   (opA[k*SEG_W +: SEG_W]),
      .segB   (opB[k*SEG_W +: SEG_W]),
      .grpGen (segGen[k]),
      .grpProp(segProp[k])
    );

    specSumGen #(.SEG_W(SEG_W)) sumGen_i (
      .segA   (opA[k*SEG_W +: SEG_W]),
      .segB   (opB[k*SEG_W +: SEG_W]),
      .carryIn(carryIn[k]),
      .segSum (sum[k*SEG_W +: SEG_W])
    );
  end

  specCarryNet #(.SEGS(SEGS), .MODE(MODE)) carryNet_i (
    .lowGen (segGen[SEGS-2:0]),
    .lowProp(segProp[SEGS-2:0]),
    .carryIn(carryIn)
  );

  assign carryOut = segGen[TOP] | (segProp[TOP] & carryIn[TOP]);

  // Port-level checks
  always_comb begin
    logic [SEG_W-1:0] lowRef;
    logic [WIDTH:0]   fullRef;
    lowRef  = opA[SEG_W-1:0] + opB[SEG_W-1:0];
    fullRef = {1'b0, opA} + {1'b0, opB};

    assert_low_seg_exact_R2: assert (sum[SEG_W-1:0] == lowRef);

    if ((opA & opB) == '0)
      assert_no_gen_plain_xor_R7: assert (sum == (opA ^ opB) && !carryOut);

    if (carryOut)
      assert_carry_needs_top_bit_R5: assert (opA[WIDTH-1] | opB[WIDTH-1]);

    if (MODE == MODE_CASCADE && SEGS <= 4)
      assert_cascade_exact_R8: assert ({carryOut, sum} == fullRef);
  end

endmodule

// File: tb/specAdder_tb_top.sv
module specAdder_tb_top;
  import spec_adder_pkg::*;

  localparam int WIDTH = 16;
  localparam int SEGS  = 4;
  localparam int SEG_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [WIDTH-1:0] opA, opB;
  logic [WIDTH-1:0] sumBas, sumCas;
  logic             coutBas, coutCas;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  specAdder #(.WIDTH(WIDTH), .SEGS(SEGS), .MODE(MODE_BASIC)) dut_i (
    .opA(opA), .opB(opB), .sum(sumBas), .carryOut(coutBas));

  specAdder #(.WIDTH(WIDTH), .SEGS(SEGS), .MODE(MODE_CASCADE)) dut_cas_i (
    .opA(opA), .opB(opB), .sum(sumCas), .carryOut(coutCas));

  // Window-based model: each segment's carry-in is the carry out of the
  // sum of a window of lower slices added with zero carry.
  function automatic logic [WIDTH:0] refAdd(input logic [WIDTH-1:0] a,
                                            input logic [WIDTH-1:0] b,
                                            input bit cas);
    logic [WIDTH:0] r;
    int unsigned wa, wb, t, mask;
    int w, lo, cin;
    r = '0;
    for (int k = 0; k < SEGS; k++) begin
      cin = 0;
      if (k > 0) begin
        w = cas ? ((k == SEGS - 1) ? 3 : 2) : 1;
        if (w > k) w = k;
        lo = (k - w) * SEG_W;
        mask = (32'd1 << (w * SEG_W)) - 1;
        wa = (32'(a) >> lo) & mask;
        wb = (32'(b) >> lo) & mask;
        t = wa + wb;
        cin = int'((t >> (w * SEG_W)) & 1);
      end
      t = ((32'(a) >> (k * SEG_W)) & 32'hF) + ((32'(b) >> (k * SEG_W)) & 32'hF)
          + 32'(cin);
      r[k*SEG_W +: SEG_W] = t[SEG_W-1:0];
      if (k == SEGS - 1) r[WIDTH] = t[SEG_W];
    end
    return r;
  endfunction

  function automatic bit middleFullProp(input logic [WIDTH-1:0] a,
                                        input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] x;
    bit any;
    x = a ^ b;
    any = 0;
    for (int k = 1; k < SEGS - 1; k++)
      if (x[k*SEG_W +: SEG_W] == 4'hF) any = 1;
    return any;
  endfunction

  task automatic checkVal(input string req, input logic [WIDTH:0] act,
                          input logic [WIDTH:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, opA, opB, act, exp);
    end
  endtask

  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    @(posedge clk);
    opA = a;
    opB = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] a, b, m;
    logic [WIDTH:0]   exact;
    opA = '0;
    opB = '0;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Idle operands: R7 (no generate) on both builds
    checkVal("R7 idle basic", {coutBas, sumBas}, 17'h0);
    checkVal("R7 idle cascade", {coutCas, sumCas}, 17'h0);

    // Two-boundary carry dropped in basic, kept in cascade
    apply(16'h00FF, 16'h0001);
    checkVal("R9 basic 00FF+1", {coutBas, sumBas}, 17'h00000);
    checkVal("R8 cascade 00FF+1", {coutCas, sumCas}, 17'h00100);

    apply(16'hFFFF, 16'h0001);
    checkVal("R9 basic FFFF+1", {coutBas, sumBas}, 17'h0FF00);
    checkVal("R8 cascade FFFF+1", {coutCas, sumCas}, 17'h10000);

    apply(16'h0FFF, 16'h0001);
    checkVal("R3 basic 0FFF+1", {coutBas, sumBas}, 17'h00F00);
    checkVal("R4 cascade 0FFF+1", {coutCas, sumCas}, 17'h01000);

    // Single boundary: exact in both
    apply(16'h000F, 16'h0001);
    checkVal("R2 basic 000F+1", {coutBas, sumBas}, 17'h00010);
    checkVal("R2 cascade 000F+1", {coutCas, sumCas}, 17'h00010);

    // Top carry out
    apply(16'h8000, 16'h8000);
    checkVal("R5 basic 8000+8000", {coutBas, sumBas}, 17'h10000);
    checkVal("R5 cascade 8000+8000", {coutCas, sumCas}, 17'h10000);

    apply(16'hF0F0, 16'h1010);
    checkVal("R5 basic F0F0+1010", {coutBas, sumBas}, 17'h10100);

    // No generate anywhere
    apply(16'hAAAA, 16'h5555);
    checkVal("R7 basic AAAA+5555", {coutBas, sumBas}, 17'h0FFFF);
    checkVal("R7 cascade AAAA+5555", {coutCas, sumCas}, 17'h0FFFF);

    // Random and propagate-heavy vectors
    for (int n = 0; n < 3000; n++) begin
      a = 16'($urandom);
      if (n % 3 == 0) begin
        m = 16'($urandom);
        b = ~a ^ (m & 16'h000F);
        if (n % 2 == 0) b[0] = ~b[0];
      end else if (n % 3 == 1) begin
        b = 16'($urandom) & ~a;
      end else begin
        b = 16'($urandom);
      end
      apply(a, b);
      exact = {1'b0, a} + {1'b0, b};
      checkVal("R1 R3 R5 basic model", {coutBas, sumBas}, refAdd(a, b, 1'b0));
      checkVal("R1 R4 R5 cascade model", {coutCas, sumCas}, refAdd(a, b, 1'b1));
      checkVal("R8 cascade exact", {coutCas, sumCas}, exact);
      checkVal("R2 low segment", {13'h0, sumBas[3:0]}, {13'h0, exact[3:0]});
      if (!middleFullProp(a, b))
        checkVal("R6 basic exact", {coutBas, sumBas}, exact);
      if ((a & b) == '0)
        checkVal("R7 xor", {coutBas, sumBas}, {1'b0, a ^ b});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule